// File: doc/BRIEF.md
# Configurable Register Output Cell for a Product-Term Array

This block is one output cell for a small programmable logic array. A set of native product terms, plus a configurable subset of borrowed product terms, is OR-ed into a single sum. That sum feeds a one-bit register that behaves as a D, T, JK or SR storage element, depending on a two-bit configuration field. For JK and SR behaviour, the second input comes from a separate auxiliary product term.

The register advances on a rising edge of one of two clock sources. A configuration bit chooses between a dedicated clock pin and a product-term clock. Preset and clear are active-high product-term signals, and clear may come from either of two terms. A configuration bit decides whether the registered value or the raw combinational sum drives the cell output. The same value is returned on a feedback output toward the array.

A byte-wide bus can write the register or read it back. The bus uses one data bit whose position is fixed by a parameter.

Top module: `pld_outcell`

## Requirements
- R1: The sum is 1 exactly when any native term is 1, or any borrowed term whose enable bit is 1 is also 1. A borrowed term with its enable at 0 never affects the sum.
- R2: With `cfg_kind` = 0 (D), a clock rise loads the sum into the register.
- R3: With `cfg_kind` = 1 (T), a clock rise inverts the register when the sum is 1 and keeps it when the sum is 0.
- R4: With `cfg_kind` = 2 (JK, where J is the sum and K is `aux_pt`), a clock rise does the following: 00 holds, 01 clears, 10 sets, 11 inverts.
- R5: With `cfg_kind` = 3 (SR, where S is the sum and R is `aux_pt`), a clock rise does the following: 00 holds, 01 clears, 10 sets, 11 holds.
- R6: The register advances only on a 0-to-1 change of the selected clock source. `cfg_clk_sel` = 0 selects `pin_clk` and 1 selects `clk_pt`, and the source that is not selected has no effect.
- R7: While `preset_pt` is 1 and no clear term is 1, the registered value reads 1 in the same cycle, and 1 stays stored after the preset is removed.
- R8: While either bit of `clr_pt` is 1, the registered value reads 0 in the same cycle and 0 is stored. Clear has priority over preset.
- R9: When `bus_wr` is 1 without preset or clear, the next register value is `bus_wdata[BIT_POS]` (default bit 5), even if a clock rise happens in the same cycle.
- R10: `bus_rdata` carries the registered value at bit `BIT_POS` while `bus_rd` is 1, and zeros elsewhere. It is all zero otherwise, and a read leaves the register unchanged.
- R11: `cell_out` is the registered value when `cfg_out_reg` is 1 and the sum when it is 0. `fb_out` always equals `cell_out`.
- R12: Reset (`rst_n` low) clears the register. A clock source that is already high when reset ends does not count as a rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all inputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| native_pt | input | NATIVE_PT | Native product terms |
| borrow_pt | input | MAX_BORROW | Borrowed product terms |
| borrow_en | input | MAX_BORROW | Per-term enable for borrowed terms |
| aux_pt | input | 1 | Second register input (K or R) |
| cfg_kind | input | 2 | Register behaviour: 0 D, 1 T, 2 JK, 3 SR |
| cfg_clk_sel | input | 1 | Clock source: 0 pin, 1 product term |
| cfg_out_reg | input | 1 | Output source: 1 registered, 0 combinational |
| pin_clk | input | 1 | Dedicated clock input |
| clk_pt | input | 1 | Product-term clock |
| preset_pt | input | 1 | Active-high preset term |
| clr_pt | input | 2 | Two active-high clear terms, OR-ed |
| bus_wr | input | 1 | Bus load strobe |
| bus_rd | input | 1 | Bus read strobe |
| bus_wdata | input | DATA_W | Bus write data |
| bus_rdata | output | DATA_W | Bus read data |
| cell_out | output | 1 | Cell output to the pin |
| fb_out | output | 1 | Feedback to the array |

## Verification
The bench targets a clock input that is already high when reset is released. A design that primes its edge detector with 0 would take a false clock there. It also runs JK with both inputs at 1 and SR with both inputs at 1, where swapped encodings would show up as a hold instead of a toggle, or the reverse. Two further cases are preset and clear asserted together, where the wrong priority drives 1, and a bus write that coincides with a clock rise, where a design that lets the clock win stores the sum instead of the bus bit. A disabled borrowed term and the unselected clock source are driven actively, so a design that ignores the enable mask or the clock selection changes `cell_out`.

// File: rtl/omc_pkg.sv
package omc_pkg;

    typedef enum logic [1:0] {
        FF_D  = 2'd0,
        FF_T  = 2'd1,
        FF_JK = 2'd2,
        FF_SR = 2'd3
    } ff_kind_e;

    typedef struct packed {
        logic stored;
    } cell_state_t;

endpackage

// File: rtl/omc_term_sum.sv
module omc_term_sum #(
    parameter int NATIVE_PT  = 3,
    parameter int MAX_BORROW = 6
) (
    input  logic [NATIVE_PT-1:0]  native_i,
    input  logic [MAX_BORROW-1:0] borrow_i,
    input  logic [MAX_BORROW-1:0] enable_i,
    output logic                  sum_o
);
    localparam int TERM_W = NATIVE_PT + MAX_BORROW;

    logic [MAX_BORROW-1:0] taken;
    logic [TERM_W-1:0]     all_terms;

    // Mask every borrowed term with its own enable bit.
    for (genvar i = 0; i < MAX_BORROW; i++) begin : g_borrow
        assign taken[i] = borrow_i[i] & enable_i[i];
    end

    assign all_terms = {taken, native_i};
    assign sum_o     = |all_terms;
endmodule

// File: rtl/omc_edge_det.sv
module omc_edge_det #(
    parameter int SYNC_STAGES = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic rise_o
);
    // pipe_q[SYNC_STAGES] holds the previous sample; the stages below it are optional synchronizers.
    logic [SYNC_STAGES:0] pipe_d, pipe_q;
    logic                 smp;

    if (SYNC_STAGES == 0) begin : g_direct
        assign smp    = sig_i;
        assign pipe_d = sig_i;
    end else begin : g_sync
        assign smp    = pipe_q[SYNC_STAGES-1];
        assign pipe_d = {pipe_q[SYNC_STAGES-1:0], sig_i};
    end

    // Reset to all ones: a source that is already high after reset is not a rise.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '1;
        else        pipe_q <= pipe_d;
    end

    assign rise_o = smp & ~pipe_q[SYNC_STAGES];

    // R6
    edge_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/omc_next_state.sv
module omc_next_state
    import omc_pkg::*;
(
    input  ff_kind_e kind_i,
    input  logic     q_i,
    input  logic     a_i,
    input  logic     b_i,
    output logic     nxt_o
);
    always_comb begin
        nxt_o = q_i;
        unique case (kind_i)
            FF_D:  nxt_o = a_i;
            FF_T:  nxt_o = q_i ^ a_i;
            FF_JK: begin
                unique case ({a_i, b_i})
                    2'b00:   nxt_o = q_i;
                    2'b01:   nxt_o = 1'b0;
                    2'b10:   nxt_o = 1'b1;
                    default: nxt_o = ~q_i;
                endcase
            end
            default: begin
                unique case ({a_i, b_i})
                    2'b01:   nxt_o = 1'b0;
                    2'b10:   nxt_o = 1'b1;
                    default: nxt_o = q_i;
                endcase
            end
        endcase
    end
endmodule

// File: rtl/pld_outcell.sv
module pld_outcell
    import omc_pkg::*;
#(
    parameter int NATIVE_PT   = 3,
    parameter int MAX_BORROW  = 6,
    parameter int DATA_W      = 8,
    parameter int BIT_POS     = 5,
    parameter int SYNC_STAGES = 0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NATIVE_PT-1:0]  native_pt,
    input  logic [MAX_BORROW-1:0] borrow_pt,
    input  logic [MAX_BORROW-1:0] borrow_en,
    input  logic                  aux_pt,
    input  logic [1:0]            cfg_kind,
    input  logic                  cfg_clk_sel,
    input  logic                  cfg_out_reg,
    input  logic                  pin_clk,
    input  logic                  clk_pt,
    input  logic                  preset_pt,
    input  logic [1:0]            clr_pt,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic                  cell_out,
    output logic                  fb_out
);
    cell_state_t st_d, st_q;

    logic     sum;
    logic     sel_clk;
    logic     clk_rise;
    logic     ff_next;
    logic     clr_any;
    logic     reg_vis;
    ff_kind_e kind;

    omc_term_sum #(
        .NATIVE_PT (NATIVE_PT),
        .MAX_BORROW(MAX_BORROW)
    ) u_sum (
        .native_i(native_pt),
        .borrow_i(borrow_pt),
        .enable_i(borrow_en),
        .sum_o   (sum)
    );

    assign sel_clk = cfg_clk_sel ? clk_pt : pin_clk;

    omc_edge_det #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sig_i (sel_clk),
        .rise_o(clk_rise)
    );

    assign kind = ff_kind_e'(cfg_kind);

    omc_next_state u_ns (
        .kind_i(kind),
        .q_i   (st_q.stored),
        .a_i   (sum),
        .b_i   (aux_pt),
        .nxt_o (ff_next)
    );

    // Order of precedence: clear, preset, bus load, clocked update.
    always_comb begin
        clr_any = |clr_pt;
        st_d    = st_q;
        if (clr_any)        st_d.stored = 1'b0;
        else if (preset_pt) st_d.stored = 1'b1;
        else if (bus_wr)    st_d.stored = bus_wdata[BIT_POS];
        else if (clk_rise)  st_d.stored = ff_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Preset and clear override the visible value without waiting for a clock.
    always_comb begin
        if (clr_any)        reg_vis = 1'b0;
        else if (preset_pt) reg_vis = 1'b1;
        else                reg_vis = st_q.stored;
    end

    always_comb begin
        bus_rdata          = '0;
        bus_rdata[BIT_POS] = bus_rd & reg_vis;
    end

    assign cell_out = cfg_out_reg ? reg_vis : sum;
    assign fb_out   = cell_out;

    // R8
    clr_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_pt) |=> !st_q.stored);

    // R8
    clr_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_out_reg && (|clr_pt)) |-> !cell_out);

    // R7
    preset_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (preset_pt && !(|clr_pt)) |=> st_q.stored);

    // R9
    bus_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !preset_pt && !(|clr_pt)) |=> (st_q.stored == $past(bus_wdata[BIT_POS])));

    // R6
    no_edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_rise && !bus_wr && !preset_pt && !(|clr_pt)) |=> $stable(st_q.stored));

    // R10
    rdata_onebit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bus_rdata));
endmodule

// File: tb/sim_pld_outcell.sv
module sim_pld_outcell;
    localparam int NP = 3;
    localparam int NB = 6;
    localparam int DW = 8;
    localparam int BP = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] native_pt = '0;
    logic [NB-1:0] borrow_pt = '0;
    logic [NB-1:0] borrow_en = '0;
    logic          aux_pt = 1'b0;
    logic [1:0]    cfg_kind = 2'd0;
    logic          cfg_clk_sel = 1'b0;
    logic          cfg_out_reg = 1'b1;
    logic          pin_clk = 1'b1;
    logic          clk_pt = 1'b0;
    logic          preset_pt = 1'b0;
    logic [1:0]    clr_pt = 2'b00;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          cell_out;
    logic          fb_out;

    int   checks = 0;
    int   fails  = 0;
    logic exp_q    = 1'b0;
    logic exp_prev = 1'b1;

    always #10 clk = ~clk;

    pld_outcell #(
        .NATIVE_PT(NP), .MAX_BORROW(NB), .DATA_W(DW), .BIT_POS(BP), .SYNC_STAGES(0)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .native_pt(native_pt), .borrow_pt(borrow_pt),
        .borrow_en(borrow_en), .aux_pt(aux_pt), .cfg_kind(cfg_kind),
        .cfg_clk_sel(cfg_clk_sel), .cfg_out_reg(cfg_out_reg), .pin_clk(pin_clk),
        .clk_pt(clk_pt), .preset_pt(preset_pt), .clr_pt(clr_pt), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cell_out(cell_out), .fb_out(fb_out)
    );

    function automatic logic f_sum();
        return (|native_pt) | (|(borrow_pt & borrow_en));
    endfunction

    function automatic logic f_next(logic [1:0] k, logic q, logic a, logic b);
        case (k)
            2'd0: return a;
            2'd1: return q ^ a;
            2'd2: return ({a, b} == 2'b00) ? q : ({a, b} == 2'b01) ? 1'b0 :
                         ({a, b} == 2'b10) ? 1'b1 : ~q;
            default: return ({a, b} == 2'b01) ? 1'b0 : ({a, b} == 2'b10) ? 1'b1 : q;
        endcase
    endfunction

    function automatic logic f_vis();
        if (|clr_pt)   return 1'b0;
        if (preset_pt) return 1'b1;
        return exp_q;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] ev);
        checks++;
        if (act !== ev) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, ev);
        end
    endtask

    task automatic check_outs(string tag);
        logic          eo;
        logic [DW-1:0] er;
        eo = cfg_out_reg ? f_vis() : f_sum();
        er = '0;
        er[BP] = bus_rd & f_vis();
        chk({tag, " out"}, cell_out, eo);
        chk({tag, " fb"},  fb_out, eo);
        chk({tag, " rd"},  bus_rdata, er);
    endtask

    // Called at a falling edge with the inputs already set.
    task automatic step(string tag);
        logic sel, rise;
        #1 check_outs(tag);
        @(posedge clk);
        if (!rst_n) begin
            exp_q    = 1'b0;
            exp_prev = 1'b1;
        end else begin
            sel  = cfg_clk_sel ? clk_pt : pin_clk;
            rise = sel & ~exp_prev;
            if (|clr_pt)        exp_q = 1'b0;
            else if (preset_pt) exp_q = 1'b1;
            else if (bus_wr)    exp_q = bus_wdata[BP];
            else if (rise)      exp_q = f_next(cfg_kind, exp_q, f_sum(), aux_pt);
            exp_prev = sel;
        end
        #1 check_outs(tag);
        @(negedge clk);
    endtask

    task automatic pulse_pin(string tag);
        pin_clk = 1'b0; step(tag);
        pin_clk = 1'b1; step(tag);
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        @(negedge clk);
        // R12: reset holds the register at 0
        step("R12 reset");
        step("R12 reset");
        native_pt = 3'b001; rst_n = 1'b1;
        step("R12 high clock at release");
        chk("R12 no false rise", cell_out, 1'b0);

        // R2: D loads the sum
        pulse_pin("R2 load one");
        chk("R2 q", cell_out, 1'b1);
        native_pt = '0;
        pulse_pin("R2 load zero");

        // R1: sum with masked borrowed terms, combinational output
        cfg_out_reg = 1'b0; borrow_pt = 6'b100000; borrow_en = 6'b011111;
        step("R1 disabled borrow");
        chk("R1 masked", cell_out, 1'b0);
        borrow_en = 6'b100000;
        step("R1 enabled borrow");
        native_pt = 3'b100; borrow_en = '0;
        step("R1 native");

        // R11: output mux selects register
        cfg_out_reg = 1'b1; native_pt = '0; borrow_pt = '0;
        step("R11 reg select");

        // R3: T toggles on sum
        cfg_kind = 2'd1; native_pt = 3'b010;
        pulse_pin("R3 toggle");
        pulse_pin("R3 toggle again");
        native_pt = '0;
        pulse_pin("R3 hold");

        // R4: JK
        cfg_kind = 2'd2; native_pt = 3'b001; aux_pt = 1'b1;
        pulse_pin("R4 jk11");
        pulse_pin("R4 jk11 again");
        native_pt = '0;
        pulse_pin("R4 jk01");
        native_pt = 3'b001; aux_pt = 1'b0;
        pulse_pin("R4 jk10");

        // R5: SR
        cfg_kind = 2'd3; aux_pt = 1'b1;
        pulse_pin("R5 sr11 hold");
        chk("R5 hold", cell_out, 1'b1);
        native_pt = '0;
        pulse_pin("R5 sr01");

        // R6: unselected source ignored
        cfg_kind = 2'd0; native_pt = 3'b001; cfg_clk_sel = 1'b1;
        pulse_pin("R6 pin ignored");
        chk("R6 unchanged", cell_out, 1'b0);
        clk_pt = 1'b1;
        step("R6 term clock");
        chk("R6 term rise", cell_out, 1'b1);
        clk_pt = 1'b0; native_pt = '0;
        step("R6 fall no update");
        cfg_clk_sel = 1'b0;

        // R7: preset visible at once and stored
        preset_pt = 1'b1;
        #1 chk("R7 immediate", cell_out, 1'b1);
        step("R7 preset");
        preset_pt = 1'b0;
        step("R7 kept");

        // R8: either clear term, wins over preset
        preset_pt = 1'b1; clr_pt = 2'b10;
        #1 chk("R8 clear wins", cell_out, 1'b0);
        step("R8 both");
        preset_pt = 1'b0; clr_pt = 2'b00;
        step("R8 stored");
        preset_pt = 1'b1; step("R8 reset set");
        preset_pt = 1'b0; clr_pt = 2'b01;
        step("R8 term zero");
        clr_pt = 2'b00;

        // R9: bus write beats a same-cycle clock rise
        native_pt = '0; pin_clk = 1'b0; step("R9 prep");
        pin_clk = 1'b1; bus_wr = 1'b1; bus_wdata = 8'h20;
        step("R9 write over clock");
        bus_wr = 1'b0;
        step("R9 after");
        chk("R9 kept bus bit", cell_out, 1'b1);

        // R10: read returns bit BP only, no disturbance
        bus_rd = 1'b1;
        step("R10 read");
        chk("R10 data", bus_rdata, 8'h20);
        bus_rd = 1'b0;
        step("R10 idle");
        chk("R10 unchanged", cell_out, 1'b1);

        // Random mix
        for (int i = 0; i < 600; i++) begin
            native_pt   = ($urandom % 4 == 0) ? NP'($urandom) : '0;
            borrow_pt   = NB'($urandom);
            borrow_en   = NB'($urandom);
            aux_pt      = 1'($urandom);
            cfg_kind    = 2'($urandom);
            cfg_clk_sel = ($urandom % 8 == 0) ? ~cfg_clk_sel : cfg_clk_sel;
            cfg_out_reg = 1'($urandom);
            pin_clk     = 1'($urandom);
            clk_pt      = 1'($urandom);
            preset_pt   = ($urandom % 10 == 0);
            clr_pt      = ($urandom % 12 == 0) ? 2'($urandom) : 2'b00;
            bus_wr      = ($urandom % 8 == 0);
            bus_rd      = 1'($urandom);
            bus_wdata   = DW'($urandom);
            step("RND mixed");
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule